// File: doc/BRIEF.md
# Queued Multi-Channel SPI Master

This block is an SPI master with a host-side register bus. It serves up to sixteen logical channels. Each channel has its own descriptor, which sets the following: which chip select to drive, the frame length, the SCLK divisor, clock polarity and phase, a delayed-sampling option, and whether received bits are kept.

The host writes 32-bit words into the data window. The low address bits of the write name the target channel, so each queued word carries its channel tag. All channels share one transmit FIFO. A shifting engine takes words from it in order and runs one SPI frame for each word, using the descriptor of that word's channel. When a channel keeps its receive data, the captured frame goes into one shared receive FIFO. The host can therefore match replies to requests purely by order, even when the requests went to many different channels.

A status word reports both FIFO levels and two sticky overflow flags. Writing the status word empties both FIFOs and clears the flags. This is meant for start-up only.

Top module: `qspi_master`

## Requirements
- R1: The register bus decodes `bus_addr[5:4]`: 0 is the data window, 1 is the descriptor bank, 2 is status. A write to address 0x0N queues `bus_wdata` for channel N.
- R2: The transmit and receive FIFOs are each 16 words deep. Status bits [4:0] hold the TX level and bits [12:8] hold the RX level, and both read 0 after reset.
- R3: Received words leave the RX FIFO in the order in which their transactions were queued, whatever the mix of channels.
- R4: When a frame completes, one word is added to the RX FIFO only if the keep flag (descriptor bit 16) of its channel is 1. Frames on channels whose keep flag is 0 add nothing.
- R5: During a frame, only `cs_n[cs]` is low, where cs is descriptor bits [20:17]. It falls one half period before the first SCLK edge and rises one half period after the last edge. A half period is divisor+1 clocks, where the divisor is descriptor bits [12:5].
- R6: A frame of L bits (L-1 in descriptor bits [4:0]) produces exactly 2L SCLK edges. SCLK rests at CPOL (descriptor bit 13) when the chip select falls.
- R7: Transmit bits go out MSB first, starting from bit L-1. Received bits are right-justified with zeros above them. With MOSI looped to MISO, the returned word equals the low L bits of the sent word for every combination of CPHA (bit 14) and late sampling (bit 15).
- R8: The TX level drops to 0 as soon as the last word is taken for shifting, even though its frame is still running.
- R9: A push into a full TX FIFO is dropped and sets status bit 16. A capture into a full RX FIFO is dropped and sets status bit 17. Both flags stay set until cleared.
- R10: Any write to the status address empties both FIFOs and clears both overflow flags.
- R11: A descriptor written at address 0x1N reads back from the same address in bits [20:0], with zeros above.
- R12: A read from any address in the data window pops the oldest RX word. A read while the RX FIFO is empty returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe (pops RX in the data window) |
| bus_rdata | output | 32 | Read data, combinational from the address |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 16 | Active-low chip selects |

## Verification
The assertions assume two things about the bus. First, a read strobe lasts one clock per intended pop. Second, the host does not change a channel's descriptor while frames for that channel are still queued, because the engine latches the descriptor only when it takes the word.

The stimulus follows both rules. It writes every descriptor before queuing traffic, and it waits until the TX level is 0 and all chip selects are high before it reconfigures or reads. Random bursts never exceed sixteen words, except in the deliberate overflow cases.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = 5;
  localparam int DIV_W  = 8;
  localparam int CS_W   = 4;
  localparam int K_W    = LEN_W + 2;

  typedef struct packed {
    logic [CS_W-1:0]  cs;
    logic             keep;
    logic             late;
    logic             cpha;
    logic             cpol;
    logic [DIV_W-1:0] div;
    logic [LEN_W-1:0] lenm1;
  } desc_t;

  localparam int DESC_W = $bits(desc_t);

  function automatic logic [K_W-1:0] frame_len(desc_t d);
    return {2'b00, d.lenm1} + K_W'(1);
  endfunction

  // half-period tick k samples MISO when k = cpha + late + 2i, i < len
  function automatic logic samp_tick(logic [K_W-1:0] k, desc_t d);
    logic [K_W-1:0] s0, off;
    s0 = K_W'(d.cpha) + K_W'(d.late);
    if (k < s0) return 1'b0;
    off = k - s0;
    return !off[0] && ((off >> 1) < frame_len(d));
  endfunction

  // tick k advances MOSI to the next bit
  function automatic logic drive_tick(logic [K_W-1:0] k, desc_t d,
                                      logic [K_W-1:0] sent);
    return (k != '0) && (k[0] != d.cpha) && (sent + K_W'(1) < frame_len(d));
  endfunction
endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    dout,
  output logic [CNTW-1:0] count,
  output logic            full,
  output logic            empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CNTW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) if (do_push && !clr) mem[wp] <= din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      count <= count + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));
  a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    push && full && !pop && !clr |=> count == CNTW'(DEPTH));
  a_r10_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
  import qspi_pkg::*;
#(
  parameter int NCS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_word,
  input  desc_t             tx_desc,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [WORD_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n,
  output logic              busy
);
  desc_t             cur;
  logic [WORD_W-1:0] txw, rxsr;
  logic [DIV_W-1:0]  hp;
  logic [K_W-1:0]    k, sent, bit_idx;
  logic              tick, last_tick, samp_now;

  assign tx_pop    = !busy && tx_valid;
  assign tick      = busy && (hp == cur.div);
  assign last_tick = tick && (k == (frame_len(cur) << 1));
  assign samp_now  = tick && samp_tick(k, cur);
  assign rx_push   = last_tick && cur.keep;
  assign rx_word   = samp_now ? {rxsr[WORD_W-2:0], miso} : rxsr;
  assign bit_idx   = frame_len(cur) - K_W'(1) - sent;
  assign mosi      = busy && txw[bit_idx[LEN_W-1:0]];
  assign cs_n      = busy ? ~(NCS'(1) << cur.cs) : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cur <= '0; txw <= '0; rxsr <= '0;
      hp <= '0; k <= '0; sent <= '0; sclk <= 1'b0;
    end else if (tx_pop) begin
      busy <= 1'b1; cur <= tx_desc; txw <= tx_word; rxsr <= '0;
      hp <= '0; k <= '0; sent <= '0; sclk <= tx_desc.cpol;
    end else if (busy) begin
      if (tick) begin
        hp <= '0;
        k  <= k + K_W'(1);
        if (k < (frame_len(cur) << 1)) sclk <= ~sclk;
        if (samp_now) rxsr <= {rxsr[WORD_W-2:0], miso};
        if (drive_tick(k, cur, sent)) sent <= sent + K_W'(1);
        if (last_tick) busy <= 1'b0;
      end else begin
        hp <= hp + DIV_W'(1);
      end
    end
  end

  a_r5_cs_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r6_sclk_rest: assert property (@(posedge clk) disable iff (!rst_n)
    busy && k == '0 |-> sclk == cur.cpol);
  a_r4_push_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !busy);
  a_r8_pop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> busy && !$stable(cs_n));
endmodule

// File: rtl/qspi_master.sv
module qspi_master
  import qspi_pkg::*;
#(
  parameter int NCHAN = 16,
  parameter int DEPTH = 16,
  localparam int CHW  = $clog2(NCHAN),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [5:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCHAN-1:0]  cs_n
);
  localparam logic [1:0] SEL_DATA = 2'd0, SEL_DESC = 2'd1, SEL_STAT = 2'd2;
  localparam int TXW = WORD_W + CHW;

  desc_t             dsc [NCHAN];
  logic [CHW-1:0]    ch;
  logic              wr_data, wr_stat, rd_data;
  logic              tx_full, tx_empty, rx_full, rx_empty, tx_pop, rx_push;
  logic [TXW-1:0]    tx_head;
  logic [WORD_W-1:0] rx_head, rx_word;
  logic [CNTW-1:0]   tx_cnt, rx_cnt;
  logic              tx_ovf, rx_ovf, eng_busy;

  assign ch      = bus_addr[CHW-1:0];
  assign wr_data = bus_wr && bus_addr[5:4] == SEL_DATA;
  assign wr_stat = bus_wr && bus_addr[5:4] == SEL_STAT;
  assign rd_data = bus_rd && bus_addr[5:4] == SEL_DATA;

  for (genvar i = 0; i < NCHAN; i++) begin : g_desc
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) dsc[i] <= '0;
      else if (bus_wr && bus_addr[5:4] == SEL_DESC && ch == CHW'(i))
        dsc[i] <= desc_t'(bus_wdata[DESC_W-1:0]);
  end

  qspi_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txq (
    .clk, .rst_n, .clr(wr_stat), .push(wr_data), .din({ch, bus_wdata}),
    .pop(tx_pop), .dout(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  qspi_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk, .rst_n, .clr(wr_stat), .push(rx_push), .din(rx_word),
    .pop(rd_data), .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  qspi_engine #(.NCS(NCHAN)) u_eng (
    .clk, .rst_n, .tx_valid(!tx_empty), .tx_word(tx_head[WORD_W-1:0]),
    .tx_desc(dsc[tx_head[TXW-1:WORD_W]]), .tx_pop, .rx_push, .rx_word,
    .sclk, .mosi, .miso, .cs_n, .busy(eng_busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0; rx_ovf <= 1'b0;
    end else if (wr_stat) begin
      tx_ovf <= 1'b0; rx_ovf <= 1'b0;
    end else begin
      if (wr_data && tx_full) tx_ovf <= 1'b1;
      if (rx_push && rx_full) rx_ovf <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr[5:4])
      SEL_DATA: bus_rdata = rx_empty ? '0 : rx_head;
      SEL_DESC: bus_rdata = 32'(dsc[ch]);
      SEL_STAT: begin
        bus_rdata[4:0]  = 5'(tx_cnt);
        bus_rdata[12:8] = 5'(rx_cnt);
        bus_rdata[16]   = tx_ovf;
        bus_rdata[17]   = rx_ovf;
      end
      default: bus_rdata = '0;
    endcase
  end

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovf || rx_ovf) && !wr_stat |=> (tx_ovf || rx_ovf));
  a_r10_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> !tx_ovf && !rx_ovf && tx_cnt == '0);
  a_r5_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> cs_n == '1);
endmodule

// File: tb/qspi_master_tb.sv
module qspi_master_tb;
  logic        clk = 0, rst_n = 0;
  logic [5:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        sclk, mosi;
  logic [15:0] cs_n;

  qspi_master u_dut (.clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd,
    .bus_rdata, .sclk, .mosi, .miso(mosi), .cs_n);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench-side descriptor model
  int d_len[16], d_div[16], d_cs[16];
  bit d_cpol[16], d_cpha[16], d_late[16], d_keep[16];

  function automatic logic [31:0] pack_desc(int ln, int dv, bit po, bit ph,
                                            bit lt, bit kp, int cs);
    return (32'(cs) << 17) | (32'(kp) << 16) | (32'(lt) << 15) |
           (32'(ph) << 14) | (32'(po) << 13) | (32'(dv) << 5) | 32'(ln - 1);
  endfunction
  function automatic logic [31:0] low_bits(logic [31:0] w, int ln);
    return (ln >= 32) ? w : (w & ((32'd1 << ln) - 32'd1));
  endfunction

  // monitor of each frame on the wire
  int m_cs[64], m_edges[64], m_lead[64], m_total[64], m_n = 0;
  bit m_idle[64];
  bit in_fr = 0, seen = 0, lastc = 0;
  int e_c, l_c, t_c, cs_c;
  bit idl;
  always @(negedge clk) if (rst_n) begin
    if (!in_fr && cs_n != 16'hffff) begin
      in_fr = 1; seen = 0; lastc = sclk; idl = sclk; e_c = 0; l_c = 0; t_c = 0;
      cs_c = -1;
      for (int i = 0; i < 16; i++) if (!cs_n[i]) cs_c = i;
    end
    if (in_fr) begin
      if (cs_n == 16'hffff) begin
        if (m_n < 64) begin
          m_cs[m_n] = cs_c; m_edges[m_n] = e_c; m_lead[m_n] = l_c;
          m_total[m_n] = t_c; m_idle[m_n] = idl;
        end
        m_n++; in_fr = 0;
      end else begin
        t_c++;
        if (sclk != lastc) begin e_c++; seen = 1; end
        lastc = sclk;
        if (!seen) l_c++;
      end
    end
  end

  task automatic bus_write(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic bus_pop(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic peek(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    do peek(6'h20, s); while (!(s[4:0] == 0 && cs_n == 16'hffff));
    repeat (3) @(negedge clk);
  endtask

  int e_ch[64];
  logic [31:0] e_w[64], kept[64];

  task automatic run_round(int n);
    int kn = 0;
    logic [31:0] s, r;
    m_n = 0;
    for (int i = 0; i < n; i++) begin
      e_ch[i] = $urandom % 16; e_w[i] = $urandom;
      bus_write(6'(e_ch[i]), e_w[i]);
      if (d_keep[e_ch[i]]) begin kept[kn] = low_bits(e_w[i], d_len[e_ch[i]]); kn++; end
    end
    wait_idle();
    check(m_n == n, "R1 frame count", m_n, n);
    for (int i = 0; i < n && i < m_n; i++) begin
      int c = e_ch[i];
      check(m_cs[i] == d_cs[c], "R5 cs select", m_cs[i], d_cs[c]);
      check(m_lead[i] == d_div[c] + 1, "R5 cs lead", m_lead[i], d_div[c] + 1);
      check(m_total[i] == (2 * d_len[c] + 1) * (d_div[c] + 1), "R5 cs hold",
            m_total[i], (2 * d_len[c] + 1) * (d_div[c] + 1));
      check(m_edges[i] == 2 * d_len[c], "R6 edge count", m_edges[i], 2 * d_len[c]);
      check(m_idle[i] == d_cpol[c], "R6 idle level", m_idle[i], d_cpol[c]);
    end
    peek(6'h20, s);
    check(s[12:8] == 5'(kn), "R4 rx level equals kept frames", s[12:8], kn);
    for (int i = 0; i < kn; i++) begin
      bus_pop(6'($urandom % 16), r);
      check(r == kept[i], "R3 R7 rx order and data", r, kept[i]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] s, r;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk); rst_n = 1;
    peek(6'h20, s);
    check(s == 0, "R2 reset status", s, 0);
    check(cs_n == 16'hffff, "R5 reset cs idle", cs_n, 16'hffff);
    peek(6'h00, s);
    check(s == 0, "R12 empty read", s, 0);

    // random descriptors, with readback
    for (int c = 0; c < 16; c++) begin
      d_len[c] = 1 + $urandom % 32; d_div[c] = $urandom % 4; d_cs[c] = $urandom % 16;
      d_cpol[c] = 1'($urandom); d_cpha[c] = 1'($urandom); d_late[c] = 1'($urandom);
      d_keep[c] = ($urandom % 4) != 0;
      if (c == 0) d_len[c] = 32;
      if (c == 1) d_len[c] = 1;
      s = pack_desc(d_len[c], d_div[c], d_cpol[c], d_cpha[c], d_late[c], d_keep[c], d_cs[c]);
      bus_write(6'h10 | 6'(c), s | 32'hffe0_0000);
      peek(6'h10 | 6'(c), r);
      check(r == s, "R11 descriptor readback", r, s);
    end
    for (int k = 0; k < 8; k++) run_round(1 + $urandom % 16);

    // R2 R9 R12: rx overflow, pop from any data address
    bus_write(6'h12, pack_desc(8, 0, 0, 0, 0, 1, 2));
    for (int i = 0; i < 16; i++) bus_write(6'h02, 32'(i + 1));
    wait_idle();
    peek(6'h20, s);
    check(s[12:8] == 16, "R2 rx full level", s[12:8], 16);
    check(s[17] == 0, "R9 no rx ovf yet", s[17], 0);
    bus_write(6'h02, 32'hab);
    wait_idle();
    peek(6'h20, s);
    check(s[17] == 1, "R9 rx ovf sticky", s[17], 1);
    check(s[12:8] == 16, "R9 rx drop", s[12:8], 16);
    bus_pop(6'h07, r);
    check(r == 1, "R12 pop oldest", r, 1);
    bus_pop(6'h0c, r);
    check(r == 2, "R12 pop next", r, 2);
    peek(6'h20, s);
    check(s[17] == 1, "R9 flag held", s[17], 1);
    bus_write(6'h20, 0);
    peek(6'h20, s);
    check(s == 0, "R10 clear", s, 0);
    peek(6'h05, r);
    check(r == 0, "R12 empty after clear", r, 0);

    // R8: tx level 0 while last frame still shifting
    bus_write(6'h15, pack_desc(8, 20, 1, 0, 0, 0, 5));
    bus_write(6'h05, 32'h5a);
    repeat (30) @(negedge clk);
    peek(6'h20, s);
    check(s[4:0] == 0, "R8 tx level drained", s[4:0], 0);
    check(cs_n[5] == 0, "R8 frame still active", cs_n[5], 0);
    wait_idle();

    // R9 tx overflow, R10 clear
    for (int i = 0; i < 20; i++) bus_write(6'h05, 32'(i));
    peek(6'h20, s);
    check(s[4:0] == 16, "R9 tx level capped", s[4:0], 16);
    check(s[16] == 1, "R9 tx ovf", s[16], 1);
    bus_write(6'h20, 0);
    peek(6'h20, s);
    check(s[4:0] == 0 && s[16] == 0, "R10 tx clear", s, 0);
    wait_idle();
    peek(6'h20, s);
    check(s[12:8] == 0, "R4 no keep no capture", s[12:8], 0);

    // R7 directed: every CPHA/late combination, full and short frames
    for (int m = 0; m < 4; m++) begin
      d_len[3] = (m % 2) ? 32 : 5; d_div[3] = 1; d_cs[3] = 9; d_cpol[3] = m[0];
      d_cpha[3] = m[1]; d_late[3] = m[0] ^ m[1]; d_keep[3] = 1;
      bus_write(6'h13, pack_desc(d_len[3], 1, d_cpol[3], d_cpha[3], d_late[3], 1, 9));
      bus_write(6'h03, 32'hc35a_96e1);
      wait_idle();
      bus_pop(6'h00, r);
      check(r == low_bits(32'hc35a_96e1, d_len[3]), "R7 loopback mode", r,
            low_bits(32'hc35a_96e1, d_len[3]));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule